// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block moves a 16-bit segmented core from "an interrupt is wanted" to "the service routine's first fetch may begin". At each instruction boundary it looks at every pending cause, picks one by a fixed priority and settles on an 8-bit type number. The causes are a divide error, a software `INT n` from the decoder, the one-byte breakpoint, `INTO` with overflow set, a latched rising edge on the non-maskable pin, the maskable request pin, and the single-step trap. A maskable request first runs a two-pulse acknowledge handshake. The type number is taken from the low byte of the data bus during the second pulse.

Once a type is chosen, the block saves the machine state on the stack. It writes three 16-bit words: the flags first, then the code segment, then the instruction pointer. Each write goes to `SS*16 + SP` after SP has been lowered by 2. The block then reads the two-word vector entry at physical address `type*4`. The word at offset 0 is the new IP and the word at offset 2 is the new CS. In one cycle it hands the core the new CS, IP and SP, together with the saved flags with trap and interrupt-enable cleared. It raises a done pulse in the following cycle. The core supplies the current register values and owns the register file. Each memory access is a 16-bit word that completes in the cycle where `mem_rdy_i` is high.

Top module: `intr_entry_seq`

States and transitions: `S_IDLE` goes to `S_ACK1` on a granted maskable request, or to `S_PUSH_FL` on any other grant. `S_ACK1` goes to `S_ACK_GAP`, then to `S_ACK2`, then to `S_PUSH_FL`. `S_PUSH_FL` goes to `S_PUSH_CS`, then `S_PUSH_IP`, then `S_RD_IP`, then `S_RD_CS`, then `S_LOAD`, each step taken on a cycle with ready. `S_LOAD` goes to `S_DONE`, and `S_DONE` goes back to `S_IDLE`.

## Requirements
- R1: Each entry writes exactly three words, in this order: flags at `SS*16+((SP-2) mod 2^16)`, CS at `SP-4`, IP at `SP-6`. The new SP handed to the core is `SP-6` (mod 2^16).
- R2: The pushed flags word equals the flags at grant time. The new flags word equals that value with bit 8 (trap) and bit 9 (interrupt enable) cleared and every other bit kept.
- R3: After the three writes, exactly two reads follow: the new IP from `type*4`, then the new CS from `type*4+2`. The vector table occupies physical addresses 0 to 1023.
- R4: `load_o` is high for one cycle and carries the IP and CS just read. `done_o` is high in the next cycle and at no other time.
- R5: A rising edge on `nmi_i` is serviced as type 2. This happens whatever the value of flag bit 9, and no acknowledge pulse is produced. An edge that arrives while the block is busy stays pending until serviced, and is serviced once only.
- R6: `intr_i` is taken only when flag bit 9 is 1. It produces two one-cycle `inta_o` pulses with one low cycle between them. The type is the `ack_data_i` value during the second pulse. `intr_i` with bit 9 clear causes no activity.
- R7: With flag bit 8 set at a boundary and nothing else pending, type 1 is taken.
- R8: A breakpoint request gives type 3. `INTO` gives type 4 only when flag bit 11 (overflow) is 1. With bit 11 clear it has no effect.
- R9: A divide-error request gives type 0.
- R10: Priority from highest to lowest is: divide error, `INT n`, breakpoint, `INTO` with overflow, NMI, enabled INTR, single-step.
- R11: Requests are sampled only while idle and `boundary_i` is high. While `mem_rdy_i` is low, the pending access holds its request, address and direction.
- R12: `INT n` uses the type number given on `swi_type_i`, for all 256 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boundary_i | input | 1 | Current instruction has finished |
| div_err_i | input | 1 | Divide error raised by the instruction just finished |
| swi_req_i | input | 1 | Software interrupt instruction decoded |
| swi_type_i | input | TYPE_W | Type operand of the software interrupt |
| brk_req_i | input | 1 | One-byte breakpoint decoded |
| into_req_i | input | 1 | Overflow-check instruction decoded |
| nmi_i | input | 1 | Non-maskable request pin, edge sensitive |
| intr_i | input | 1 | Maskable request pin, level sensitive |
| inta_o | output | 1 | Acknowledge pulse |
| ack_data_i | input | TYPE_W | Low byte of the data bus during acknowledge |
| flags_i | input | DATA_W | Current flags word |
| cs_i | input | DATA_W | Current code segment |
| ip_i | input | DATA_W | Return instruction pointer |
| ss_i | input | DATA_W | Stack segment |
| sp_i | input | DATA_W | Stack pointer |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Physical byte address of the word |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rdata_i | input | DATA_W | Read data, valid with ready |
| mem_rdy_i | input | 1 | Access completes this cycle |
| load_o | output | 1 | Load new CS, IP, SP and flags |
| new_cs_o | output | DATA_W | New code segment |
| new_ip_o | output | DATA_W | New instruction pointer |
| new_sp_o | output | DATA_W | New stack pointer |
| new_flags_o | output | DATA_W | New flags word |
| done_o | output | 1 | Entry finished, fetch may start |

## Verification
The embedded properties are checked on every cycle. They cover the following: an access held still through a stall, every read falling inside the vector table, done following load, acknowledge pulses never adjacent and never overlapping memory traffic, loaded flags always having trap and enable clear, an NMI edge never dropped before its grant, and a maskable grant never made with interrupts disabled. Some behaviour can only be shown by the bench scenarios. This includes the exact push order and addresses, the SP wrap, the vector values reaching CS:IP, and the type chosen for each cause and combination of causes. It also includes a pending NMI being serviced later exactly once, and masked or non-overflowing requests leaving the bus silent.

// File: rtl/intr_entry_pkg.sv
package intr_entry_pkg;

    // flag bit positions of the core's flags word
    localparam int TF_BIT = 8;
    localparam int IF_BIT = 9;
    localparam int OF_BIT = 11;

    // physical address = segment << SEG_SHIFT + offset
    localparam int SEG_SHIFT = 4;

    // fixed type numbers
    localparam logic [7:0] TYPE_DIV  = 8'd0;
    localparam logic [7:0] TYPE_STEP = 8'd1;
    localparam logic [7:0] TYPE_NMI  = 8'd2;
    localparam logic [7:0] TYPE_BRK  = 8'd3;
    localparam logic [7:0] TYPE_OVF  = 8'd4;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_DIV,
        SRC_SWI,
        SRC_BRK,
        SRC_OVF,
        SRC_NMI,
        SRC_INTR,
        SRC_STEP
    } src_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ACK1,
        S_ACK_GAP,
        S_ACK2,
        S_PUSH_FL,
        S_PUSH_CS,
        S_PUSH_IP,
        S_RD_IP,
        S_RD_CS,
        S_LOAD,
        S_DONE
    } seq_state_e;

endpackage

// File: rtl/intr_src_arb.sv
module intr_src_arb
    import intr_entry_pkg::*;
#(
    parameter int TYPE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              div_err_i,
    input  logic              swi_req_i,
    input  logic [TYPE_W-1:0] swi_type_i,
    input  logic              brk_req_i,
    input  logic              into_req_i,
    input  logic              of_i,
    input  logic              if_i,
    input  logic              tf_i,
    input  logic              nmi_i,
    input  logic              intr_i,
    input  logic              take_i,
    output logic              req_o,
    output src_e              src_o,
    output logic [TYPE_W-1:0] type_o
);

    logic nmi_q;
    logic nmi_pend_q;
    logic nmi_edge;
    logic nmi_any;

    assign nmi_edge = nmi_i & ~nmi_q;
    assign nmi_any  = nmi_pend_q | nmi_edge;

    // fixed priority chain
    always_comb begin
        src_o  = SRC_NONE;
        type_o = '0;
        if (div_err_i) begin
            src_o  = SRC_DIV;
            type_o = TYPE_W'(TYPE_DIV);
        end else if (swi_req_i) begin
            src_o  = SRC_SWI;
            type_o = swi_type_i;
        end else if (brk_req_i) begin
            src_o  = SRC_BRK;
            type_o = TYPE_W'(TYPE_BRK);
        end else if (into_req_i && of_i) begin
            src_o  = SRC_OVF;
            type_o = TYPE_W'(TYPE_OVF);
        end else if (nmi_any) begin
            src_o  = SRC_NMI;
            type_o = TYPE_W'(TYPE_NMI);
        end else if (intr_i && if_i) begin
            src_o  = SRC_INTR;
            type_o = '0;
        end else if (tf_i) begin
            src_o  = SRC_STEP;
            type_o = TYPE_W'(TYPE_STEP);
        end
    end

    assign req_o = (src_o != SRC_NONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_q      <= 1'b0;
            nmi_pend_q <= 1'b0;
        end else begin
            nmi_q <= nmi_i;
            if (take_i && src_o == SRC_NMI)
                nmi_pend_q <= 1'b0;
            else
                nmi_pend_q <= nmi_any;
        end
    end

    // R5: a latched edge survives until its own grant
    a_r5_nmi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pend_q && !(take_i && src_o == SRC_NMI) |=> nmi_pend_q);

    // R6: maskable source only chosen with enable set
    a_r6_intr_masked: assert property (@(posedge clk) disable iff (!rst_n)
        src_o == SRC_INTR |-> if_i && intr_i);

endmodule

// File: rtl/intr_entry_fsm.sv
module intr_entry_fsm
    import intr_entry_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int TYPE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary_i,
    input  logic              req_i,
    input  src_e              src_i,
    input  logic [TYPE_W-1:0] type_i,
    input  logic [TYPE_W-1:0] ack_data_i,
    input  logic [DATA_W-1:0] flags_i,
    input  logic [DATA_W-1:0] cs_i,
    input  logic [DATA_W-1:0] ip_i,
    input  logic [DATA_W-1:0] ss_i,
    input  logic [DATA_W-1:0] sp_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_rdy_i,
    output logic              take_o,
    output logic              inta_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              load_o,
    output logic [DATA_W-1:0] new_cs_o,
    output logic [DATA_W-1:0] new_ip_o,
    output logic [DATA_W-1:0] new_sp_o,
    output logic [DATA_W-1:0] new_flags_o,
    output logic              done_o
);

    localparam int WORD_BYTES  = DATA_W / 8;
    localparam int ENTRY_BYTES = 2 * WORD_BYTES;
    localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);
    localparam logic [DATA_W-1:0] CLR_MASK =
        ~((DATA_W'(1) << TF_BIT) | (DATA_W'(1) << IF_BIT));

    seq_state_e state_q, state_d;

    logic [TYPE_W-1:0] type_q;
    logic [DATA_W-1:0] flags_q, cs_q, ip_q, ss_q, sp_q;
    logic [DATA_W-1:0] vip_q, vcs_q;
    logic [DATA_W-1:0] sp_dec;
    logic [ADDR_W-1:0] stk_addr;
    logic [ADDR_W-1:0] vec_addr;
    logic              pushing;

    assign take_o   = (state_q == S_IDLE) && boundary_i && req_i;
    assign sp_dec   = sp_q - DATA_W'(WORD_BYTES);
    assign stk_addr = (ADDR_W'(ss_q) << SEG_SHIFT) + ADDR_W'(sp_dec);
    assign vec_addr = ADDR_W'(type_q) << ENTRY_SHIFT;
    assign pushing  = (state_q == S_PUSH_FL) || (state_q == S_PUSH_CS) ||
                      (state_q == S_PUSH_IP);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (take_o) state_d = (src_i == SRC_INTR) ? S_ACK1 : S_PUSH_FL;
            S_ACK1:    state_d = S_ACK_GAP;
            S_ACK_GAP: state_d = S_ACK2;
            S_ACK2:    state_d = S_PUSH_FL;
            S_PUSH_FL: if (mem_rdy_i) state_d = S_PUSH_CS;
            S_PUSH_CS: if (mem_rdy_i) state_d = S_PUSH_IP;
            S_PUSH_IP: if (mem_rdy_i) state_d = S_RD_IP;
            S_RD_IP:   if (mem_rdy_i) state_d = S_RD_CS;
            S_RD_CS:   if (mem_rdy_i) state_d = S_LOAD;
            S_LOAD:    state_d = S_DONE;
            S_DONE:    state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // captured context and vector
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            type_q  <= '0;
            flags_q <= '0;
            cs_q    <= '0;
            ip_q    <= '0;
            ss_q    <= '0;
            sp_q    <= '0;
            vip_q   <= '0;
            vcs_q   <= '0;
        end else begin
            if (take_o) begin
                type_q  <= type_i;
                flags_q <= flags_i;
                cs_q    <= cs_i;
                ip_q    <= ip_i;
                ss_q    <= ss_i;
                sp_q    <= sp_i;
            end
            if (state_q == S_ACK2)
                type_q <= ack_data_i;
            if (pushing && mem_rdy_i)
                sp_q <= sp_dec;
            if (state_q == S_RD_IP && mem_rdy_i)
                vip_q <= mem_rdata_i;
            if (state_q == S_RD_CS && mem_rdy_i)
                vcs_q <= mem_rdata_i;
        end
    end

    // outputs
    always_comb begin
        inta_o      = 1'b0;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        load_o      = 1'b0;
        done_o      = 1'b0;
        unique case (state_q)
            S_ACK1, S_ACK2: inta_o = 1'b1;
            S_PUSH_FL: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = stk_addr;
                mem_wdata_o = flags_q;
            end
            S_PUSH_CS: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = stk_addr;
                mem_wdata_o = cs_q;
            end
            S_PUSH_IP: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = stk_addr;
                mem_wdata_o = ip_q;
            end
            S_RD_IP: begin
                mem_req_o  = 1'b1;
                mem_addr_o = vec_addr;
            end
            S_RD_CS: begin
                mem_req_o  = 1'b1;
                mem_addr_o = vec_addr + ADDR_W'(WORD_BYTES);
            end
            S_LOAD:  load_o = 1'b1;
            S_DONE:  done_o = 1'b1;
            default: ;
        endcase
    end

    assign new_cs_o    = vcs_q;
    assign new_ip_o    = vip_q;
    assign new_sp_o    = sp_q;
    assign new_flags_o = flags_q & CLR_MASK;

    // R11: stalled access is held unchanged
    a_r11_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_rdy_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

    // R3: every read lands inside the vector table
    a_r3_read_in_table: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_we_o |-> (mem_addr_o >> (TYPE_W + ENTRY_SHIFT)) == '0);

    // R4: done follows load by one cycle
    a_r4_done_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> done_o && !load_o);

    // R6: two separate pulses, never with memory traffic
    a_r6_inta_gap: assert property (@(posedge clk) disable iff (!rst_n)
        inta_o |=> !inta_o);
    a_r6_no_mem_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
        inta_o |-> !mem_req_o);

    // R2: service routine starts with trap and enable clear
    a_r2_flags_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> !new_flags_o[TF_BIT] && !new_flags_o[IF_BIT]);

endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq
    import intr_entry_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int TYPE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary_i,
    input  logic              div_err_i,
    input  logic              swi_req_i,
    input  logic [TYPE_W-1:0] swi_type_i,
    input  logic              brk_req_i,
    input  logic              into_req_i,
    input  logic              nmi_i,
    input  logic              intr_i,
    output logic              inta_o,
    input  logic [TYPE_W-1:0] ack_data_i,
    input  logic [DATA_W-1:0] flags_i,
    input  logic [DATA_W-1:0] cs_i,
    input  logic [DATA_W-1:0] ip_i,
    input  logic [DATA_W-1:0] ss_i,
    input  logic [DATA_W-1:0] sp_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_rdy_i,
    output logic              load_o,
    output logic [DATA_W-1:0] new_cs_o,
    output logic [DATA_W-1:0] new_ip_o,
    output logic [DATA_W-1:0] new_sp_o,
    output logic [DATA_W-1:0] new_flags_o,
    output logic              done_o
);

    logic              take;
    logic              req;
    src_e              src;
    logic [TYPE_W-1:0] sel_type;

    intr_src_arb #(.TYPE_W(TYPE_W)) arb_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .div_err_i  (div_err_i),
        .swi_req_i  (swi_req_i),
        .swi_type_i (swi_type_i),
        .brk_req_i  (brk_req_i),
        .into_req_i (into_req_i),
        .of_i       (flags_i[OF_BIT]),
        .if_i       (flags_i[IF_BIT]),
        .tf_i       (flags_i[TF_BIT]),
        .nmi_i      (nmi_i),
        .intr_i     (intr_i),
        .take_i     (take),
        .req_o      (req),
        .src_o      (src),
        .type_o     (sel_type)
    );

    intr_entry_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TYPE_W(TYPE_W)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .boundary_i  (boundary_i),
        .req_i       (req),
        .src_i       (src),
        .type_i      (sel_type),
        .ack_data_i  (ack_data_i),
        .flags_i     (flags_i),
        .cs_i        (cs_i),
        .ip_i        (ip_i),
        .ss_i        (ss_i),
        .sp_i        (sp_i),
        .mem_rdata_i (mem_rdata_i),
        .mem_rdy_i   (mem_rdy_i),
        .take_o      (take),
        .inta_o      (inta_o),
        .mem_req_o   (mem_req_o),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .load_o      (load_o),
        .new_cs_o    (new_cs_o),
        .new_ip_o    (new_ip_o),
        .new_sp_o    (new_sp_o),
        .new_flags_o (new_flags_o),
        .done_o      (done_o)
    );

endmodule

// File: tb/intr_entry_seq_tb_top.sv
module intr_entry_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boundary = 1'b0;
    logic        div_err = 1'b0;
    logic        swi_req = 1'b0;
    logic [7:0]  swi_type = 8'h00;
    logic        brk_req = 1'b0;
    logic        into_req = 1'b0;
    logic        nmi = 1'b0;
    logic        intr = 1'b0;
    logic        inta;
    logic [7:0]  ack_data;
    logic [15:0] flags_r = 16'h0000;
    logic [15:0] cs_r = 16'h0000;
    logic [15:0] ip_r = 16'h0000;
    logic [15:0] ss_r = 16'h0000;
    logic [15:0] sp_r = 16'h0000;
    logic        mem_req, mem_we;
    logic [19:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic        mem_rdy;
    logic        load, done;
    logic [15:0] new_cs, new_ip, new_sp, new_flags;

    logic        stall_mode = 1'b0;
    logic [1:0]  stall_ctr = 2'd0;
    logic [7:0]  ack_vec = 8'h00;

    int n_tests = 0;
    int n_fail = 0;

    // monitor state
    int          acc_tot = 0;
    int          inta_tot = 0;
    int          load_tot = 0;
    int          done_err = 0;
    logic        prev_load = 1'b0;
    logic [19:0] acc_addr [16];
    logic [15:0] acc_data [16];
    logic        acc_we   [16];
    logic [15:0] cap_cs, cap_ip, cap_sp, cap_fl;

    // per-case bases
    int base_acc = 0, base_inta = 0, base_load = 0, base_derr = 0;

    always #5 clk = ~clk;

    always @(posedge clk) stall_ctr <= stall_ctr + 2'd1;
    assign mem_rdy = !stall_mode || stall_ctr[0];

    function automatic logic [15:0] rd_model(input logic [19:0] a);
        return a[15:0] ^ 16'h5A3C ^ {12'h000, a[19:16]};
    endfunction

    assign mem_rdata = rd_model(mem_addr);
    assign ack_data  = (inta && (inta_tot - base_inta) == 2) ? ack_vec : 8'hEE;

    intr_entry_seq dut_i (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary),
        .div_err_i(div_err), .swi_req_i(swi_req), .swi_type_i(swi_type),
        .brk_req_i(brk_req), .into_req_i(into_req), .nmi_i(nmi), .intr_i(intr),
        .inta_o(inta), .ack_data_i(ack_data),
        .flags_i(flags_r), .cs_i(cs_r), .ip_i(ip_r), .ss_i(ss_r), .sp_i(sp_r),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_rdy_i(mem_rdy),
        .load_o(load), .new_cs_o(new_cs), .new_ip_o(new_ip), .new_sp_o(new_sp),
        .new_flags_o(new_flags), .done_o(done)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req && mem_rdy) begin
                acc_addr[acc_tot[3:0]] = mem_addr;
                acc_data[acc_tot[3:0]] = mem_we ? mem_wdata : mem_rdata;
                acc_we[acc_tot[3:0]]   = mem_we;
                acc_tot = acc_tot + 1;
            end
            if (inta) inta_tot = inta_tot + 1;
            if (load) begin
                cap_cs = new_cs; cap_ip = new_ip; cap_sp = new_sp; cap_fl = new_flags;
                load_tot = load_tot + 1;
            end
            if ((prev_load && !done) || (done && !prev_load)) done_err = done_err + 1;
            prev_load = load;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic fire(input bit dv, input bit sw, input logic [7:0] st, input bit bk,
                        input bit io, input bit nm, input bit ir);
        @(negedge clk);
        base_acc = acc_tot; base_inta = inta_tot; base_load = load_tot; base_derr = done_err;
        div_err = dv; swi_req = sw; swi_type = st; brk_req = bk; into_req = io;
        intr = ir; boundary = 1'b1;
        if (nm) nmi = 1'b1;
        @(negedge clk);
        boundary = 1'b0; div_err = 1'b0; swi_req = 1'b0; brk_req = 1'b0; into_req = 1'b0;
        nmi = 1'b0;
    endtask

    task automatic finish(input logic [7:0] et, input int ei, input string tag);
        logic [15:0] sp1, sp2, sp3;
        logic [19:0] seg;
        logic [19:0] va;
        int k;
        k = 0;
        while (load_tot == base_load && k < 200) begin
            @(negedge clk);
            k++;
        end
        chk(load_tot == base_load + 1, {tag, " R4 load seen"}, load_tot - base_load, 1);
        @(negedge clk);
        @(negedge clk);
        seg = {ss_r, 4'h0};
        sp1 = sp_r - 16'd2; sp2 = sp_r - 16'd4; sp3 = sp_r - 16'd6;
        va  = {10'h000, et, 2'b00};
        chk(acc_tot - base_acc == 5, {tag, " R1 access count"}, acc_tot - base_acc, 5);
        chk(acc_we[(base_acc+0)%16] && acc_addr[(base_acc+0)%16] == seg + {4'h0, sp1},
            {tag, " R1 flags addr"}, acc_addr[(base_acc+0)%16], seg + {4'h0, sp1});
        chk(acc_data[(base_acc+0)%16] == flags_r, {tag, " R2 pushed flags"},
            acc_data[(base_acc+0)%16], flags_r);
        chk(acc_we[(base_acc+1)%16] && acc_addr[(base_acc+1)%16] == seg + {4'h0, sp2}
            && acc_data[(base_acc+1)%16] == cs_r, {tag, " R1 cs push"},
            acc_data[(base_acc+1)%16], cs_r);
        chk(acc_we[(base_acc+2)%16] && acc_addr[(base_acc+2)%16] == seg + {4'h0, sp3}
            && acc_data[(base_acc+2)%16] == ip_r, {tag, " R1 ip push"},
            acc_data[(base_acc+2)%16], ip_r);
        chk(!acc_we[(base_acc+3)%16] && acc_addr[(base_acc+3)%16] == va,
            {tag, " R3 ip vector addr"}, acc_addr[(base_acc+3)%16], va);
        chk(!acc_we[(base_acc+4)%16] && acc_addr[(base_acc+4)%16] == va + 20'd2,
            {tag, " R3 cs vector addr"}, acc_addr[(base_acc+4)%16], va + 20'd2);
        chk(cap_ip == rd_model(va) && cap_cs == rd_model(va + 20'd2),
            {tag, " R4 new cs:ip"}, {cap_cs, cap_ip}, {rd_model(va + 20'd2), rd_model(va)});
        chk(cap_sp == sp3, {tag, " R1 new sp"}, cap_sp, sp3);
        chk(cap_fl == (flags_r & 16'hFCFF), {tag, " R2 new flags"}, cap_fl, flags_r & 16'hFCFF);
        chk(inta_tot - base_inta == ei, {tag, " R6 acknowledge pulses"}, inta_tot - base_inta, ei);
        chk(done_err == base_derr, {tag, " R4 done timing"}, done_err - base_derr, 0);
    endtask

    task automatic quiet(input string tag);
        repeat (15) @(negedge clk);
        chk(acc_tot == base_acc && load_tot == base_load && inta_tot == base_inta,
            {tag, " no activity"}, acc_tot - base_acc, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!load && !done && !mem_req && !inta, "R4 reset outputs", {load, done, mem_req, inta}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R12 + R1/R3/R11: every INT n type, stalls on odd types, SP wrap at t=0
        for (int t = 0; t < 256; t++) begin
            stall_mode = t[0];
            flags_r = {t[7:0], t[7:0]} | 16'h0300;
            cs_r = 16'hC000 ^ 16'(t); ip_r = 16'h0100 + 16'(t);
            ss_r = 16'h1000 + 16'(t * 7); sp_r = (t == 0) ? 16'h0000 : 16'h8000 - 16'(t * 2);
            fire(0, 1, t[7:0], 0, 0, 0, 0);
            finish(t[7:0], 0, "R12 intn");
        end
        stall_mode = 1'b0;
        flags_r = 16'h0200; cs_r = 16'h2222; ip_r = 16'h3333; ss_r = 16'h0400; sp_r = 16'h0100;

        // R9 divide error
        fire(1, 0, 8'h00, 0, 0, 0, 0); finish(8'd0, 0, "R9 div");
        // R8 breakpoint, INTO with and without overflow
        fire(0, 0, 8'h00, 1, 0, 0, 0); finish(8'd3, 0, "R8 brk");
        flags_r = 16'h0A00;
        fire(0, 0, 8'h00, 0, 1, 0, 0); finish(8'd4, 0, "R8 into ovf");
        flags_r = 16'h0200;
        fire(0, 0, 8'h00, 0, 1, 0, 0); quiet("R8 into no ovf");
        // R7 trap
        flags_r = 16'h0100;
        fire(0, 0, 8'h00, 0, 0, 0, 0); finish(8'd1, 0, "R7 trap");
        // R8/R7: INTO without overflow yields to trap
        flags_r = 16'h0300;
        fire(0, 0, 8'h00, 0, 1, 0, 0); finish(8'd1, 0, "R8 into ignored, trap");

        // R6 INTR with several vectors, and masked
        for (int v = 0; v < 8; v++) begin
            ack_vec = 8'h11 * 8'(v) + 8'h08;
            stall_mode = v[0];
            flags_r = 16'h0200;
            fire(0, 0, 8'h00, 0, 0, 0, 1);
            intr = 1'b0;
            finish(ack_vec, 2, "R6 intr");
        end
        stall_mode = 1'b0;
        flags_r = 16'h0000;
        fire(0, 0, 8'h00, 0, 0, 0, 1); quiet("R6 intr masked");
        intr = 1'b0;

        // R5 NMI ignores enable, no acknowledge
        flags_r = 16'h0000;
        fire(0, 0, 8'h00, 0, 0, 1, 0); finish(8'd2, 0, "R5 nmi");
        fire(0, 0, 8'h00, 0, 0, 0, 0); quiet("R5 nmi once");
        // R5 edge while busy is kept
        fire(0, 1, 8'h77, 0, 0, 0, 0);
        @(negedge clk); nmi = 1'b1;
        @(negedge clk); @(negedge clk); nmi = 1'b0;
        finish(8'h77, 0, "R5 busy intn");
        fire(0, 0, 8'h00, 0, 0, 0, 0); finish(8'd2, 0, "R5 nmi pending");
        fire(0, 0, 8'h00, 0, 0, 0, 0); quiet("R5 pending cleared");

        // R10 priority ladder
        ack_vec = 8'hA5;
        flags_r = 16'h0300;
        fire(1, 0, 8'h00, 0, 0, 1, 1); finish(8'd0, 0, "R10 div first");
        fire(0, 0, 8'h00, 0, 0, 0, 1); finish(8'd2, 0, "R10 nmi over intr");
        fire(0, 0, 8'h00, 0, 0, 0, 1); intr = 1'b0; finish(8'hA5, 2, "R10 intr over trap");
        fire(0, 1, 8'h40, 1, 0, 0, 0); finish(8'h40, 0, "R10 intn over brk");
        flags_r = 16'h0B00;
        fire(0, 0, 8'h00, 1, 1, 0, 0); finish(8'd3, 0, "R10 brk over into");
        fire(0, 0, 8'h00, 0, 1, 1, 0); finish(8'd4, 0, "R10 into over nmi");
        fire(0, 0, 8'h00, 0, 0, 0, 0); finish(8'd2, 0, "R10 nmi after into");

        // R11 requests need a boundary
        flags_r = 16'h0300;
        @(negedge clk);
        base_acc = acc_tot; base_inta = inta_tot; base_load = load_tot;
        div_err = 1'b1; swi_req = 1'b1; intr = 1'b1;
        repeat (4) @(negedge clk);
        div_err = 1'b0; swi_req = 1'b0; intr = 1'b0;
        flags_r = 16'h0000;
        quiet("R11 no boundary");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule